// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. Each entry maps a virtual page number, qualified by an address-space identifier, to a physical frame number together with write and execute permission bits. All entries are compared in parallel on every lookup. The result comes one cycle later and gives hit or miss, the frame number, the permissions and a protection fault flag. Because each entry is tagged with its address space, translations from several processes coexist and a context switch needs no flush.

When a lookup misses, the translation is produced outside the block. It is then written in through the fill port, so the next lookup of that page hits. Fills can pin an entry so replacement never picks it. Two flush inputs drop either every unpinned entry or only the unpinned entries of one address space. The entry count is a power-of-two parameter. The default of 16 keeps verification short; production sizes run from 64 to 1024.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and unpinned, all result outputs are 0, and the replacement pointer is at entry 0.
- R2: The result of a lookup appears on the clock edge after the request: `res_valid_o` equals `lk_valid_i` of the previous cycle, and `res_hit_o` is 0 whenever `res_valid_o` is 0.
- R3: A lookup hits only when a valid entry matches both the page number and the address-space identifier. On a hit, the frame number and the permission bits of that entry are returned.
- R4: On a miss, `res_hit_o`, `res_pfn_o`, `res_wr_o`, `res_ex_o` and `res_fault_o` are all 0.
- R5: Access type `lk_acc_i` is coded 00 read, 01 write, 10 execute, with 11 handled as read. A hit faults on a write to an entry without write permission, or on an execute of an entry without execute permission. A read never faults, and a miss never faults.
- R6: A fill becomes visible to lookups made from the next cycle on. A lookup made in the same cycle as a fill sees the contents from before the fill.
- R7: A fill whose page number and identifier match a valid entry overwrites that entry in place. At most one entry ever matches a lookup.
- R8: A new translation goes into the lowest-numbered invalid entry. When every entry is valid, the victim is the first unpinned entry at or after the replacement pointer, wrapping around. The pointer then moves to the entry after the victim.
- R9: A fill with `fill_wire_i` set pins its entry, and replacement never chooses a pinned entry.
- R10: When every entry is valid and pinned, a fill that matches no entry is dropped.
- R11: `flush_all_i` invalidates every unpinned entry. Pinned entries survive.
- R12: `flush_asid_i` invalidates only the unpinned entries whose identifier equals `flush_id_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_asid_i | input | ASID_W | Address-space identifier of the lookup |
| lk_acc_i | input | 2 | Access type: 00 read, 01 write, 10 execute |
| res_valid_o | output | 1 | Lookup result is valid |
| res_hit_o | output | 1 | Translation found |
| res_pfn_o | output | PFN_W | Physical frame number on a hit |
| res_wr_o | output | 1 | Entry allows writes |
| res_ex_o | output | 1 | Entry allows execution |
| res_fault_o | output | 1 | Access type violates the permissions of the hit entry |
| fill_valid_i | input | 1 | Write a translation |
| fill_vpn_i | input | VPN_W | Page number of the fill |
| fill_asid_i | input | ASID_W | Identifier of the fill |
| fill_pfn_i | input | PFN_W | Frame number of the fill |
| fill_wr_i | input | 1 | Write permission of the fill |
| fill_ex_i | input | 1 | Execute permission of the fill |
| fill_wire_i | input | 1 | Pin the filled entry |
| flush_all_i | input | 1 | Invalidate all unpinned entries |
| flush_asid_i | input | 1 | Invalidate unpinned entries of one identifier |
| flush_id_i | input | ASID_W | Identifier for `flush_asid_i` |

## Verification
The bench fills the cache completely and then checks which entry each further fill evicts. A design that ignores the pointer, ignores pinning or prefers valid slots over empty ones loses a translation that should still hit. Refilling the same page with two different frame numbers exposes a design that creates duplicate entries, because its merged frame number reads back as the OR of both values. A fully pinned cache must drop a new fill without touching any pinned entry. A lookup issued in the same cycle as a fill must miss, and a design with a bypass would return a hit there. Flushing by identifier must spare other identifiers and pinned entries, and the permission cases make sure a hit on a read-only or non-executable page raises the fault only for the matching access type.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_w_i,
  input  logic              wr_x_i,
  input  logic              wr_pin_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_id_i,
  output logic [N-1:0]      hit_vec_o,
  output logic [N-1:0]      fill_match_o,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0]      pinned_o,
  output logic [PFN_W-1:0]  rd_pfn_o,
  output logic              rd_w_o,
  output logic              rd_x_o
);
  logic [N-1:0]      valid_q, pin_q, w_q, x_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      pin_q   <= '0;
      w_q     <= '0;
      x_q     <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!pin_q[i] && (flush_all_i || (flush_asid_i && asid_q[i] == flush_id_i)))
          valid_q[i] <= 1'b0;
        if (we_i && widx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          pin_q[i]   <= wr_pin_i;
          w_q[i]     <= wr_w_i;
          x_q[i]     <= wr_x_i;
          vpn_q[i]   <= wr_vpn_i;
          asid_q[i]  <= wr_asid_i;
          pfn_q[i]   <= wr_pfn_i;
        end
      end
    end
  end

  // parallel compare, one comparator pair per entry for each port
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g]    = valid_q[g] && vpn_q[g] == lk_vpn_i && asid_q[g] == lk_asid_i;
    assign fill_match_o[g] = valid_q[g] && vpn_q[g] == wr_vpn_i && asid_q[g] == wr_asid_i;
  end

  assign valid_o  = valid_q;
  assign pinned_o = pin_q & valid_q;

  // and-or readout; the hit vector is at most one-hot
  always_comb begin
    rd_pfn_o = '0;
    rd_w_o   = 1'b0;
    rd_x_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) begin
        rd_pfn_o = rd_pfn_o | pfn_q[i];
        rd_w_o   = rd_w_o | w_q[i];
        rd_x_o   = rd_x_o | x_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [N-1:0]     match_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     pinned_i,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o
);
  logic [IDX_W-1:0] rr_q, match_idx, free_idx, rr_idx, cand;
  logic             any_match, any_free, any_rr, use_rr;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    any_match = 1'b0;
    any_free  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        match_idx = IDX_W'(i);
        any_match = 1'b1;
      end
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  // first unpinned entry at or after the pointer, wrapping
  always_comb begin
    rr_idx = '0;
    any_rr = 1'b0;
    cand   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = rr_q + IDX_W'(k);
      if (!pinned_i[cand]) begin
        rr_idx = cand;
        any_rr = 1'b1;
      end
    end
  end

  always_comb begin
    use_rr = 1'b0;
    we_o   = 1'b0;
    widx_o = '0;
    if (fill_i) begin
      if (any_match) begin
        we_o   = 1'b1;
        widx_o = match_idx;
      end else if (any_free) begin
        we_o   = 1'b1;
        widx_o = free_idx;
      end else if (any_rr) begin
        we_o   = 1'b1;
        widx_o = rr_idx;
        use_rr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (use_rr) rr_q <= rr_idx + IDX_W'(1);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [1:0]        lk_acc_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [PFN_W-1:0]  res_pfn_o,
  output logic              res_wr_o,
  output logic              res_ex_o,
  output logic              res_fault_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_wr_i,
  input  logic              fill_ex_i,
  input  logic              fill_wire_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_id_i
);
  import tlb_pkg::*;

  logic [N-1:0]     hit_vec, fill_match, valid_vec, pinned_vec;
  logic [PFN_W-1:0] rd_pfn;
  logic             rd_w, rd_x, hit, fault_d, we;
  logic [IDX_W-1:0] widx;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) i_cam (
    .clk_i, .rst_ni,
    .lk_vpn_i, .lk_asid_i,
    .wr_vpn_i(fill_vpn_i), .wr_asid_i(fill_asid_i), .wr_pfn_i(fill_pfn_i),
    .wr_w_i(fill_wr_i), .wr_x_i(fill_ex_i), .wr_pin_i(fill_wire_i),
    .we_i(we), .widx_i(widx),
    .flush_all_i, .flush_asid_i, .flush_id_i,
    .hit_vec_o(hit_vec), .fill_match_o(fill_match),
    .valid_o(valid_vec), .pinned_o(pinned_vec),
    .rd_pfn_o(rd_pfn), .rd_w_o(rd_w), .rd_x_o(rd_x)
  );

  tlb_victim #(.N(N)) i_victim (
    .clk_i, .rst_ni,
    .fill_i(fill_valid_i), .match_i(fill_match),
    .valid_i(valid_vec), .pinned_i(pinned_vec),
    .we_o(we), .widx_o(widx)
  );

  assign hit = lk_valid_i && |hit_vec;

  always_comb begin
    fault_d = 1'b0;
    if (hit) begin
      if (lk_acc_i == ACC_STORE)      fault_d = !rd_w;
      else if (lk_acc_i == ACC_FETCH) fault_d = !rd_x;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_pfn_o   <= '0;
      res_wr_o    <= 1'b0;
      res_ex_o    <= 1'b0;
      res_fault_o <= 1'b0;
    end else begin
      res_valid_o <= lk_valid_i;
      res_hit_o   <= hit;
      res_pfn_o   <= hit ? rd_pfn : '0;
      res_wr_o    <= hit && rd_w;
      res_ex_o    <= hit && rd_x;
      res_fault_o <= fault_d;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int N     = 16,
  parameter int PFN_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [1:0]       lk_acc_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [PFN_W-1:0] res_pfn_o,
  input logic             res_wr_o,
  input logic             res_ex_o,
  input logic             res_fault_o,
  input logic [N-1:0]     hit_vec_i
);
  import tlb_pkg::*;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RES_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> res_valid_o == $past(lk_valid_i)); // R2
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !res_hit_o); // R2
  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i)); // R7
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_pfn_o == '0 && !res_fault_o && !res_wr_o && !res_ex_o)); // R4
  AST_READ_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(lk_acc_i) == ACC_LOAD) |-> !res_fault_o); // R5
  AST_WRITE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && res_hit_o && $past(lk_acc_i) == ACC_STORE) |-> res_fault_o == !res_wr_o); // R5
  AST_EXEC_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && res_hit_o && $past(lk_acc_i) == ACC_FETCH) |-> res_fault_o == !res_ex_o); // R5
endmodule

bind asid_tlb tlb_checker #(.N(N), .PFN_W(PFN_W)) i_tlb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_acc_i(lk_acc_i),
  .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_pfn_o(res_pfn_o),
  .res_wr_o(res_wr_o), .res_ex_o(res_ex_o), .res_fault_o(res_fault_o),
  .hit_vec_i(hit_vec)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int N = 16;
  localparam int VPN_W = 20;
  localparam int ASID_W = 8;
  localparam int PFN_W = 20;
  localparam int VW = 57;
  localparam int NV = 17;
  // op[56:55] vpn[54:35] asid[34:27] pfn[26:7] wr[6] ex[5] pin[4] acc[3:2] hit[1] fault[0]
  // op: 0 lookup, 1 fill, 2 flush all, 3 flush by id
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 20'h00010, 8'd1, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00010, 8'd1, 20'h00100, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd1, 20'h00100, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    {2'd0, 20'h00010, 8'd2, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00010, 8'd2, 20'h00200, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd2, 20'h00200, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1},
    {2'd0, 20'h00010, 8'd2, 20'h00200, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0},
    {2'd0, 20'h00010, 8'd1, 20'h00100, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1},
    {2'd0, 20'h00010, 8'd1, 20'h00100, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
    {2'd0, 20'h00011, 8'd1, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
    {2'd1, 20'h00010, 8'd1, 20'h00111, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd1, 20'h00111, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0},
    {2'd3, 20'h00000, 8'd2, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd2, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd1, 20'h00111, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    {2'd2, 20'h00000, 8'd0, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00010, 8'd1, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lk_valid_i = 1'b0;
  logic [VPN_W-1:0] lk_vpn_i = '0;
  logic [ASID_W-1:0] lk_asid_i = '0;
  logic [1:0] lk_acc_i = '0;
  logic res_valid_o, res_hit_o, res_wr_o, res_ex_o, res_fault_o;
  logic [PFN_W-1:0] res_pfn_o;
  logic fill_valid_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [ASID_W-1:0] fill_asid_i = '0;
  logic [PFN_W-1:0] fill_pfn_i = '0;
  logic fill_wr_i = 1'b0, fill_ex_i = 1'b0, fill_wire_i = 1'b0;
  logic flush_all_i = 1'b0, flush_asid_i = 1'b0;
  logic [ASID_W-1:0] flush_id_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  asid_tlb i_asid_tlb (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input bit w, input bit x, input bit pin);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = v; fill_asid_i = a; fill_pfn_i = p;
    fill_wr_i = w; fill_ex_i = x; fill_wire_i = pin;
    @(negedge clk_i);
    fill_valid_i = 1'b0; fill_wire_i = 1'b0;
  endtask

  task automatic flush(input bit all, input logic [ASID_W-1:0] id);
    @(negedge clk_i);
    flush_all_i = all; flush_asid_i = !all; flush_id_i = id;
    @(negedge clk_i);
    flush_all_i = 1'b0; flush_asid_i = 1'b0;
  endtask

  // issue a lookup, sample one edge later at the next falling edge
  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [1:0] acc,
                      input bit eh, input logic [PFN_W-1:0] ep, input bit ef, input string req);
    logic [PFN_W-1:0] xp;
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_vpn_i = v; lk_asid_i = a; lk_acc_i = acc;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    xp = eh ? ep : '0;
    check(res_valid_o && res_hit_o == eh && res_pfn_o == xp && res_fault_o == ef, req,
          {res_valid_o, res_hit_o, res_fault_o, res_pfn_o}, {1'b1, eh, ef, xp});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state at the ports
    @(negedge clk_i);
    check({res_valid_o, res_hit_o, res_fault_o, res_wr_o, res_ex_o, res_pfn_o} == '0, "R1 reset outputs",
          {res_valid_o, res_hit_o, res_fault_o, res_pfn_o}, 0);
    do_reset();

    // table walk: R3 R4 R5 R7 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      case (e[56:55])
        2'd0: look(e[54:35], e[34:27], e[3:2], e[1], e[26:7], e[0], $sformatf("R3/R4/R5/R12 vector %0d", i));
        2'd1: fill(e[54:35], e[34:27], e[26:7], e[6], e[5], e[4]);
        2'd2: flush(1'b1, '0);
        default: flush(1'b0, e[34:27]);
      endcase
    end

    // R2: latency and permission outputs
    fill(20'h50, 8'd4, 20'h0abc, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_vpn_i = 20'h50; lk_asid_i = 8'd4; lk_acc_i = 2'd0;
    #1 check(!res_valid_o, "R2 no result before edge", res_valid_o, 0);
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    check(res_valid_o && res_hit_o && res_wr_o && !res_ex_o && res_pfn_o == 20'h0abc, "R2/R3 result after one edge",
          {res_valid_o, res_hit_o, res_wr_o, res_ex_o, res_pfn_o}, {4'b1110, 20'h0abc});
    @(negedge clk_i);
    check(!res_valid_o && !res_hit_o, "R2 idle after request", {res_valid_o, res_hit_o}, 0);

    // R6: same-cycle fill and lookup sees old state
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 20'h60; fill_asid_i = 8'd4; fill_pfn_i = 20'h0def;
    fill_wr_i = 1'b0; fill_ex_i = 1'b0;
    lk_valid_i = 1'b1; lk_vpn_i = 20'h60; lk_asid_i = 8'd4; lk_acc_i = 2'd0;
    @(negedge clk_i);
    fill_valid_i = 1'b0; lk_valid_i = 1'b0;
    check(res_valid_o && !res_hit_o, "R6 same-cycle lookup misses", {res_valid_o, res_hit_o}, 2'b10);
    look(20'h60, 8'd4, 2'd1, 1'b1, 20'h0def, 1'b1, "R6 next lookup hits");

    // R7: refill of same page must not duplicate
    do_reset();
    fill(20'h70, 8'd5, 20'h0f0, 1'b0, 1'b0, 1'b0);
    fill(20'h70, 8'd5, 20'h00f, 1'b0, 1'b0, 1'b0);
    look(20'h70, 8'd5, 2'd0, 1'b1, 20'h00f, 1'b0, "R7 overwrite in place");

    // R8: empty slots first, then round-robin
    do_reset();
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 8'd3, 20'h500 + 20'(i), 1'b0, 1'b0, 1'b0);
    look(20'h10f, 8'd3, 2'd0, 1'b1, 20'h50f, 1'b0, "R8 all slots filled");
    fill(20'h200, 8'd3, 20'h600, 1'b0, 1'b0, 1'b0);
    look(20'h100, 8'd3, 2'd0, 1'b0, 20'h0, 1'b0, "R8 first victim entry 0");
    look(20'h101, 8'd3, 2'd0, 1'b1, 20'h501, 1'b0, "R8 entry 1 kept");
    look(20'h200, 8'd3, 2'd0, 1'b1, 20'h600, 1'b0, "R8 new entry hits");
    fill(20'h201, 8'd3, 20'h601, 1'b0, 1'b0, 1'b0);
    look(20'h101, 8'd3, 2'd0, 1'b0, 20'h0, 1'b0, "R8 second victim entry 1");
    look(20'h102, 8'd3, 2'd0, 1'b1, 20'h502, 1'b0, "R8 entry 2 kept");
    // empty slot preferred over round-robin
    flush(1'b0, 8'd3);
    fill(20'h202, 8'd9, 20'h602, 1'b0, 1'b0, 1'b0);
    fill(20'h203, 8'd9, 20'h603, 1'b0, 1'b0, 1'b0);
    look(20'h202, 8'd9, 2'd0, 1'b1, 20'h602, 1'b0, "R8 free slot reused");

    // R9: pinned entries skipped
    do_reset();
    for (int i = 0; i < N; i++) fill(20'h300 + 20'(i), 8'd6, 20'h700 + 20'(i), 1'b1, 1'b1, i < 2);
    fill(20'h400, 8'd6, 20'h800, 1'b0, 1'b0, 1'b0);
    look(20'h300, 8'd6, 2'd2, 1'b1, 20'h700, 1'b0, "R9 pinned entry 0 kept");
    look(20'h301, 8'd6, 2'd0, 1'b1, 20'h701, 1'b0, "R9 pinned entry 1 kept");
    look(20'h302, 8'd6, 2'd0, 1'b0, 20'h0, 1'b0, "R9 first unpinned evicted");
    // R11: flush all spares pinned
    flush(1'b1, '0);
    look(20'h300, 8'd6, 2'd0, 1'b1, 20'h700, 1'b0, "R11 pinned survives flush");
    look(20'h303, 8'd6, 2'd0, 1'b0, 20'h0, 1'b0, "R11 unpinned flushed");
    // R12: id flush spares pinned
    flush(1'b0, 8'd6);
    look(20'h301, 8'd6, 2'd0, 1'b1, 20'h701, 1'b0, "R12 pinned survives id flush");

    // R10: fully pinned drops new fill
    do_reset();
    for (int i = 0; i < N; i++) fill(20'h900 + 20'(i), 8'd7, 20'ha00 + 20'(i), 1'b0, 1'b0, 1'b1);
    fill(20'h9ff, 8'd7, 20'hbbb, 1'b0, 1'b0, 1'b0);
    look(20'h9ff, 8'd7, 2'd0, 1'b0, 20'h0, 1'b0, "R10 fill dropped");
    look(20'h900, 8'd7, 2'd0, 1'b1, 20'ha00, 1'b0, "R10 entry 0 intact");
    look(20'h90f, 8'd7, 2'd0, 1'b1, 20'ha0f, 1'b0, "R10 last entry intact");

    // R1: reset clears pinned entries too
    do_reset();
    look(20'h900, 8'd7, 2'd0, 1'b0, 20'h0, 1'b0, "R1 reset invalidates");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule